// File: doc/BRIEF.md
# Timestamping Descriptor Writeback Engine

This block walks two rings of DMA descriptors held in shared memory, one for transmit and one for receive, and closes each descriptor once its frame is done. It catches a capture time from a running seconds/nanoseconds clock when the MAC flags the start of a frame. On completion it stores that time in descriptor words 6 and 7, then hands the descriptor back to the host by rewriting word 0 with the ownership bit cleared. Descriptors are either 8 words long (extended, timestamp words present) or 4 words long (short, no timestamp words), chosen by a configuration pin.

The transmit side sleeps until the host pulses a poll-demand pin. It then fetches the current descriptor and, if the engine owns it, asks the MAC to send a frame of the length found in word 1. The receive side runs while its run pin is high and offers a completion port to the MAC only while it holds an owned receive descriptor. Both sides reach memory through one request port shared by round-robin arbitration.

The frame request (`tx_req_*`), the receive completion (`rx_cpl_*`) and the memory request (`mem_req_*`) are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. Once valid is raised, the sender keeps it and its payload steady until that transfer. Every other pin is a plain level or a one-cycle pulse.

Top module: `dtw_engine`

## Requirements
- R1: After reset, `mem_req_valid`, `tx_req_valid` and `rx_cpl_ready` are low. The transmit side is suspended, the receive side is stopped, and both ring indices are 0.
- R2: A `tx_poll` pulse makes the transmit side read word 0 of its current descriptor. If bit 31 (ownership) is clear, it raises no frame request and makes no further memory access until the next `tx_poll` pulse.
- R3: For an owned transmit descriptor, the engine reads word 1 and presents its bits 13:0 on `tx_req_len` with `tx_req_valid`. Valid and length stay steady until `tx_req_ready`.
- R4: After `tx_done`, if word 0 bit 25 is set, the descriptor is extended and `cfg_ts_en` is high, the engine writes the time captured at the last `tx_sof` to word 6 (seconds) and then to word 7 (nanoseconds). It then writes word 0 back as fetched with bit 31 cleared. With bit 25 clear it writes only word 0.
- R5: For a received frame with `cfg_ts_en` high in extended format, the engine writes word 6, then word 7, then word 0. Word 0 holds bit 31 = 0, bits 29:16 = frame length, bit 15 = error flag and bit 8 = last-segment = 1, with all other bits 0.
- R6: If a received frame arrives with `rx_cpl_ts_bad` set, or with no `rx_sof` since the previous accepted completion, words 6 and 7 are both written as 32'hFFFF_FFFF.
- R7: With `cfg_ts_en` low, neither side writes words 6 or 7, and their previous memory contents stay unchanged.
- R8: With `cfg_ext_desc` low, descriptors are 4 words apart and the engine never writes words 6 or 7.
- R9: Descriptor i of a ring sits at base + i × (8 or 4) words. After closing the last of the 4 descriptors, each side continues at index 0.
- R10: `rx_cpl_ready` is high only while the receive side holds an owned descriptor. If the fetched receive descriptor is not owned, the side waits for an `rx_poll` pulse before fetching it again.
- R11: If `rx_run` drops during a writeback, the writeback finishes. After that the receive side makes no memory access and keeps `rx_cpl_ready` low until `rx_run` returns, and it then resumes at the next index.
- R12: While `mem_req_valid` is high and `mem_req_ready` low, `mem_we`, `mem_addr` and `mem_wdata` stay steady. Read data on `mem_rdata` belongs to the same cycle as the accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ext_desc | input | 1 | 1: 8-word descriptors, 0: 4-word descriptors |
| cfg_ts_en | input | 1 | Global timestamp enable |
| rx_run | input | 1 | Receive side run control |
| tx_poll | input | 1 | Transmit poll-demand pulse |
| rx_poll | input | 1 | Receive poll-demand pulse |
| tx_ring_base | input | AW | Word address of transmit descriptor 0 |
| rx_ring_base | input | AW | Word address of receive descriptor 0 |
| ts_sec | input | 32 | Running time, seconds |
| ts_nsec | input | 32 | Running time, nanoseconds |
| tx_sof | input | 1 | Transmit frame-start strobe, captures time |
| rx_sof | input | 1 | Receive frame-start strobe, captures time |
| tx_req_valid | output | 1 | Frame request to the MAC |
| tx_req_ready | input | 1 | MAC takes the frame request |
| tx_req_len | output | 14 | Frame length in bytes |
| tx_done | input | 1 | Transmit frame finished pulse |
| rx_cpl_valid | input | 1 | Receive completion from the MAC |
| rx_cpl_ready | output | 1 | Engine takes the completion |
| rx_cpl_len | input | 14 | Received frame length |
| rx_cpl_err | input | 1 | Received frame had an error |
| rx_cpl_ts_bad | input | 1 | Capture lost for this frame |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, same cycle as accepted read |

## Verification
The hardest state to reach is a receive stop that falls in the middle of a three-word writeback, with the next descriptor at the ring wrap point. The bench drops `rx_run` right after a completion is taken. It watches the memory port go quiet, then raises the run pin again and checks that the next writeback lands at descriptor 0. The bench also keeps a receive completion pending against an unowned descriptor, to show back-pressure until the host re-arms it with `rx_poll`. Memory ready is withheld every third cycle, so arbitration and request holding are exercised while both sides compete.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int DW      = 32;
  localparam int OWN_B   = 31;
  localparam int TSE_B   = 25;
  localparam int ES_B    = 15;
  localparam int LS_B    = 8;
  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 14;
  localparam logic [2:0] WD_CTL = 3'd0;
  localparam logic [2:0] WD_LEN = 3'd1;
  localparam logic [2:0] WD_TSH = 3'd6;
  localparam logic [2:0] WD_TSL = 3'd7;

  typedef enum logic [2:0] {
    TX_SUSP, TX_RD0, TX_RD1, TX_REQ, TX_BUSY, TX_WRH, TX_WRL, TX_WR0
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_STOP, RX_SUSP, RX_RD0, RX_WAIT, RX_WRH, RX_WRL, RX_WR0
  } rx_st_e;

  function automatic logic [DW-1:0] rx_status(input logic [LEN_W-1:0] len,
                                              input logic err);
    logic [DW-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[ES_B] = err;
    w[LS_B] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/dtw_ts_capture.sv
module dtw_ts_capture #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          clr,
  input  logic [TW-1:0] sec,
  input  logic [TW-1:0] nsec,
  output logic [TW-1:0] cap_sec,
  output logic [TW-1:0] cap_nsec,
  output logic          cap_vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_sec  <= '0;
      cap_nsec <= '0;
      cap_vld  <= 1'b0;
    end else if (strobe) begin
      cap_sec  <= sec;
      cap_nsec <= nsec;
      cap_vld  <= 1'b1;
    end else if (clr) begin
      cap_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/dtw_tx_chan.sv
module dtw_tx_chan
  import dtw_pkg::*;
#(
  parameter int AW   = 16,
  parameter int RING = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext,
  input  logic             cfg_ts_en,
  input  logic [AW-1:0]    base,
  input  logic             poll,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [LEN_W-1:0] req_len,
  input  logic             done,
  input  logic [DW-1:0]    cap_sec,
  input  logic [DW-1:0]    cap_nsec,
  input  logic             cap_vld,
  output logic             cap_clr,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_we,
  output logic [AW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  output logic [2:0]       m_word,
  input  logic [DW-1:0]    m_rdata
);
  localparam int IW = (RING > 1) ? $clog2(RING) : 1;

  tx_st_e          st;
  logic [IW-1:0]   idx;
  logic [DW-1:0]   w0_q;
  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]   slot;

  assign slot = cfg_ext ? (AW'(idx) << 3) : (AW'(idx) << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= TX_SUSP;
      idx   <= '0;
      w0_q  <= '0;
      len_q <= '0;
    end else begin
      case (st)
        TX_SUSP: if (poll) st <= TX_RD0;
        TX_RD0: if (m_ready) begin
          w0_q <= m_rdata;
          st   <= m_rdata[OWN_B] ? TX_RD1 : TX_SUSP;
        end
        TX_RD1: if (m_ready) begin
          len_q <= m_rdata[LEN_W-1:0];
          st    <= TX_REQ;
        end
        TX_REQ: if (req_ready) st <= TX_BUSY;
        TX_BUSY: if (done)
          st <= (cfg_ext && cfg_ts_en && w0_q[TSE_B]) ? TX_WRH : TX_WR0;
        TX_WRH: if (m_ready) st <= TX_WRL;
        TX_WRL: if (m_ready) st <= TX_WR0;
        TX_WR0: if (m_ready) begin
          idx <= (idx == IW'(RING - 1)) ? '0 : idx + 1'b1;
          st  <= TX_RD0;
        end
        default: st <= TX_SUSP;
      endcase
    end
  end

  always_comb begin
    m_valid = 1'b0;
    m_we    = 1'b0;
    m_word  = WD_CTL;
    m_wdata = '0;
    case (st)
      TX_RD0: m_valid = 1'b1;
      TX_RD1: begin m_valid = 1'b1; m_word = WD_LEN; end
      TX_WRH: begin
        m_valid = 1'b1; m_we = 1'b1; m_word = WD_TSH;
        m_wdata = cap_vld ? cap_sec : '1;
      end
      TX_WRL: begin
        m_valid = 1'b1; m_we = 1'b1; m_word = WD_TSL;
        m_wdata = cap_vld ? cap_nsec : '1;
      end
      TX_WR0: begin
        m_valid = 1'b1; m_we = 1'b1;
        m_wdata = w0_q & ~(32'd1 << OWN_B);
      end
      default: ;
    endcase
  end

  assign m_addr    = base + slot + AW'(m_word);
  assign req_valid = (st == TX_REQ);
  assign req_len   = len_q;
  assign cap_clr   = (st == TX_REQ) && req_ready;
endmodule

// File: rtl/dtw_rx_chan.sv
module dtw_rx_chan
  import dtw_pkg::*;
#(
  parameter int AW   = 16,
  parameter int RING = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext,
  input  logic             cfg_ts_en,
  input  logic [AW-1:0]    base,
  input  logic             run,
  input  logic             poll,
  input  logic             cpl_valid,
  output logic             cpl_ready,
  input  logic [LEN_W-1:0] cpl_len,
  input  logic             cpl_err,
  input  logic             cpl_ts_bad,
  input  logic [DW-1:0]    cap_sec,
  input  logic [DW-1:0]    cap_nsec,
  input  logic             cap_vld,
  output logic             cap_clr,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_we,
  output logic [AW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  output logic [2:0]       m_word,
  input  logic             m_own
);
  localparam int IW = (RING > 1) ? $clog2(RING) : 1;

  rx_st_e           st;
  logic [IW-1:0]    idx;
  logic [LEN_W-1:0] len_q;
  logic             err_q;
  logic [DW-1:0]    hi_q, lo_q;
  logic             good;
  logic [AW-1:0]    slot;

  assign slot = cfg_ext ? (AW'(idx) << 3) : (AW'(idx) << 2);
  assign good = cap_vld && !cpl_ts_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= RX_STOP;
      idx   <= '0;
      len_q <= '0;
      err_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      case (st)
        RX_STOP: if (run) st <= RX_RD0;
        RX_SUSP: begin
          if (!run) st <= RX_STOP;
          else if (poll) st <= RX_RD0;
        end
        RX_RD0: if (m_ready) st <= m_own ? RX_WAIT : RX_SUSP;
        RX_WAIT: begin
          if (cpl_valid) begin
            len_q <= cpl_len;
            err_q <= cpl_err;
            hi_q  <= good ? cap_sec : '1;
            lo_q  <= good ? cap_nsec : '1;
            st    <= (cfg_ts_en && cfg_ext) ? RX_WRH : RX_WR0;
          end else if (!run) begin
            st <= RX_STOP;
          end
        end
        RX_WRH: if (m_ready) st <= RX_WRL;
        RX_WRL: if (m_ready) st <= RX_WR0;
        RX_WR0: if (m_ready) begin
          idx <= (idx == IW'(RING - 1)) ? '0 : idx + 1'b1;
          st  <= run ? RX_RD0 : RX_STOP;
        end
        default: st <= RX_STOP;
      endcase
    end
  end

  always_comb begin
    m_valid = 1'b0;
    m_we    = 1'b0;
    m_word  = WD_CTL;
    m_wdata = '0;
    case (st)
      RX_RD0: m_valid = 1'b1;
      RX_WRH: begin m_valid = 1'b1; m_we = 1'b1; m_word = WD_TSH; m_wdata = hi_q; end
      RX_WRL: begin m_valid = 1'b1; m_we = 1'b1; m_word = WD_TSL; m_wdata = lo_q; end
      RX_WR0: begin m_valid = 1'b1; m_we = 1'b1; m_wdata = rx_status(len_q, err_q); end
      default: ;
    endcase
  end

  assign m_addr    = base + slot + AW'(m_word);
  assign cpl_ready = (st == RX_WAIT);
  assign cap_clr   = (st == RX_WAIT) && cpl_valid;
endmodule

// File: rtl/dtw_mem_arb.sv
module dtw_mem_arb #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic last_b, hold, hold_b, pick_b;

  always_comb begin
    if (hold)                    pick_b = hold_b;
    else if (a_valid && b_valid) pick_b = !last_b;
    else                         pick_b = b_valid;
  end

  assign mem_req_valid = pick_b ? b_valid : a_valid;
  assign mem_we        = pick_b ? b_we    : a_we;
  assign mem_addr      = pick_b ? b_addr  : a_addr;
  assign mem_wdata     = pick_b ? b_wdata : a_wdata;
  assign a_ready       = mem_req_ready && !pick_b;
  assign b_ready       = mem_req_ready && pick_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_b <= 1'b0;
      hold   <= 1'b0;
      hold_b <= 1'b0;
    end else begin
      hold   <= mem_req_valid && !mem_req_ready;
      hold_b <= pick_b;
      if (mem_req_valid && mem_req_ready) last_b <= pick_b;
    end
  end
endmodule

// File: rtl/dtw_engine.sv
module dtw_engine
  import dtw_pkg::*;
#(
  parameter int AW   = 16,
  parameter int RING = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_desc,
  input  logic             cfg_ts_en,
  input  logic             rx_run,
  input  logic             tx_poll,
  input  logic             rx_poll,
  input  logic [AW-1:0]    tx_ring_base,
  input  logic [AW-1:0]    rx_ring_base,
  input  logic [31:0]      ts_sec,
  input  logic [31:0]      ts_nsec,
  input  logic             tx_sof,
  input  logic             rx_sof,
  output logic             tx_req_valid,
  input  logic             tx_req_ready,
  output logic [13:0]      tx_req_len,
  input  logic             tx_done,
  input  logic             rx_cpl_valid,
  output logic             rx_cpl_ready,
  input  logic [13:0]      rx_cpl_len,
  input  logic             rx_cpl_err,
  input  logic             rx_cpl_ts_bad,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata
);
  localparam int NCAP = 2;

  logic [NCAP-1:0] cap_stb, cap_clr, cap_vld;
  logic [DW-1:0]   cap_sec [NCAP];
  logic [DW-1:0]   cap_nsec[NCAP];

  logic          tx_m_valid, tx_m_ready, tx_m_we;
  logic [AW-1:0] tx_m_addr;
  logic [DW-1:0] tx_m_wdata;
  logic [2:0]    tx_m_word;
  logic          rx_m_valid, rx_m_ready, rx_m_we;
  logic [AW-1:0] rx_m_addr;
  logic [DW-1:0] rx_m_wdata;
  logic [2:0]    rx_m_word;
  logic          tx_cclr, rx_cclr;

  assign cap_stb = {rx_sof, tx_sof};
  assign cap_clr = {rx_cclr, tx_cclr};

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    dtw_ts_capture #(.TW(DW)) u_cap (
      .clk(clk), .rst_n(rst_n), .strobe(cap_stb[g]), .clr(cap_clr[g]),
      .sec(ts_sec), .nsec(ts_nsec),
      .cap_sec(cap_sec[g]), .cap_nsec(cap_nsec[g]), .cap_vld(cap_vld[g])
    );
  end

  dtw_tx_chan #(.AW(AW), .RING(RING)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg_ext(cfg_ext_desc), .cfg_ts_en(cfg_ts_en),
    .base(tx_ring_base), .poll(tx_poll),
    .req_valid(tx_req_valid), .req_ready(tx_req_ready), .req_len(tx_req_len),
    .done(tx_done),
    .cap_sec(cap_sec[0]), .cap_nsec(cap_nsec[0]), .cap_vld(cap_vld[0]),
    .cap_clr(tx_cclr),
    .m_valid(tx_m_valid), .m_ready(tx_m_ready), .m_we(tx_m_we),
    .m_addr(tx_m_addr), .m_wdata(tx_m_wdata), .m_word(tx_m_word),
    .m_rdata(mem_rdata)
  );

  dtw_rx_chan #(.AW(AW), .RING(RING)) u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_ext(cfg_ext_desc), .cfg_ts_en(cfg_ts_en),
    .base(rx_ring_base), .run(rx_run), .poll(rx_poll),
    .cpl_valid(rx_cpl_valid), .cpl_ready(rx_cpl_ready), .cpl_len(rx_cpl_len),
    .cpl_err(rx_cpl_err), .cpl_ts_bad(rx_cpl_ts_bad),
    .cap_sec(cap_sec[1]), .cap_nsec(cap_nsec[1]), .cap_vld(cap_vld[1]),
    .cap_clr(rx_cclr),
    .m_valid(rx_m_valid), .m_ready(rx_m_ready), .m_we(rx_m_we),
    .m_addr(rx_m_addr), .m_wdata(rx_m_wdata), .m_word(rx_m_word),
    .m_own(mem_rdata[OWN_B])
  );

  dtw_mem_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .a_valid(rx_m_valid), .a_ready(rx_m_ready), .a_we(rx_m_we),
    .a_addr(rx_m_addr), .a_wdata(rx_m_wdata),
    .b_valid(tx_m_valid), .b_ready(tx_m_ready), .b_we(tx_m_we),
    .b_addr(tx_m_addr), .b_wdata(tx_m_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/dtw_checker.sv
module dtw_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_ext_desc,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          tx_req_valid,
  input logic          tx_req_ready,
  input logic [13:0]   tx_req_len,
  input logic          tx_m_valid,
  input logic          tx_m_ready,
  input logic          tx_m_we,
  input logic [2:0]    tx_m_word,
  input logic [31:0]   tx_m_wdata,
  input logic          rx_m_valid,
  input logic          rx_m_ready,
  input logic          rx_m_we,
  input logic [2:0]    rx_m_word,
  input logic [31:0]   rx_m_wdata
);
  logic rx_wr, tx_wr, saw6, saw7;
  assign rx_wr = rx_m_valid && rx_m_ready && rx_m_we;
  assign tx_wr = tx_m_valid && tx_m_ready && tx_m_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saw6 <= 1'b0;
      saw7 <= 1'b0;
    end else if (rx_wr) begin
      saw6 <= (rx_m_word == 3'd6);
      saw7 <= (rx_m_word == 3'd7);
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R12
  AST_TXREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid && !tx_req_ready |=> tx_req_valid && $stable(tx_req_len)); // R3
  AST_TX_W0_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_m_valid && tx_m_we && tx_m_word == 3'd0 |-> !tx_m_wdata[31]); // R4
  AST_RX_W0_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_m_valid && rx_m_we && rx_m_word == 3'd0 |-> !rx_m_wdata[31] && rx_m_wdata[8]); // R5
  AST_RX_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    saw6 && rx_wr |-> rx_m_word == 3'd7); // R5
  AST_RX_LO_THEN_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    saw7 && rx_wr |-> rx_m_word == 3'd0); // R5
  AST_SHORT_NO_TS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ext_desc && (rx_wr || tx_wr) |-> (rx_wr ? rx_m_word : tx_m_word) == 3'd0); // R8
endmodule

bind dtw_engine dtw_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ext_desc(cfg_ext_desc),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready), .tx_req_len(tx_req_len),
  .tx_m_valid(tx_m_valid), .tx_m_ready(tx_m_ready), .tx_m_we(tx_m_we),
  .tx_m_word(tx_m_word), .tx_m_wdata(tx_m_wdata),
  .rx_m_valid(rx_m_valid), .rx_m_ready(rx_m_ready), .rx_m_we(rx_m_we),
  .rx_m_word(rx_m_word), .rx_m_wdata(rx_m_wdata)
);

// File: tb/dtw_engine_tb.sv
`timescale 1ns/1ps
module dtw_engine_tb;
  localparam int AW = 16;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] TSE = 32'h0200_0000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic cfg_ext_desc = 1, cfg_ts_en = 1, rx_run = 0, tx_poll = 0, rx_poll = 0;
  logic [AW-1:0] tx_ring_base = 16'd0, rx_ring_base = 16'd64;
  logic [31:0] ts_sec = 0, ts_nsec = 0;
  logic tx_sof = 0, rx_sof = 0, tx_req_ready = 0, tx_done = 0;
  logic rx_cpl_valid = 0, rx_cpl_err = 0, rx_cpl_ts_bad = 0;
  logic [13:0] rx_cpl_len = 0;
  logic tx_req_valid, rx_cpl_ready, mem_req_valid, mem_we;
  logic mem_req_ready = 0;
  logic [13:0] tx_req_len;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [128];
  int n_chk = 0, n_fail = 0, acc_cnt = 0, cyc = 0;
  logic [AW-1:0] exp_a[$];
  logic [31:0]   exp_d[$];
  string         exp_r[$];

  always #4 clk = ~clk;

  dtw_engine #(.AW(AW), .RING(4)) u_dut (.*);

  assign mem_rdata = mem[mem_addr[6:0]];
  always @(posedge clk)
    if (mem_req_valid && mem_req_ready && mem_we) mem[mem_addr[6:0]] <= mem_wdata;

  initial forever begin
    @(posedge clk);
    cyc++;
    mem_req_ready <= (cyc % 3 != 2);
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic expw(input logic [AW-1:0] a, input logic [31:0] d, input string rq);
    exp_a.push_back(a); exp_d.push_back(d); exp_r.push_back(rq);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      acc_cnt++;
      if (mem_we) begin
        if (exp_a.size() == 0) chk(0, "R7 unexpected write addr", 32'(mem_addr), 32'hFFFF);
        else begin
          logic [AW-1:0] ea; logic [31:0] ed; string er;
          ea = exp_a.pop_front(); ed = exp_d.pop_front(); er = exp_r.pop_front();
          chk(mem_addr == ea, {er, " addr"}, 32'(mem_addr), 32'(ea));
          chk(mem_wdata == ed, {er, " data"}, mem_wdata, ed);
        end
      end
    end
  end

  task automatic drain();
    while (exp_a.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_txp();
    @(negedge clk); tx_poll = 1; @(negedge clk); tx_poll = 0;
  endtask

  task automatic tx_serve(input logic [13:0] len, input logic [31:0] s, input logic [31:0] ns, input string rq);
    while (!tx_req_valid) @(negedge clk);
    chk(tx_req_len == len, rq, 32'(tx_req_len), 32'(len));
    tx_req_ready = 1; @(negedge clk); tx_req_ready = 0;
    ts_sec = s; ts_nsec = ns; tx_sof = 1; @(negedge clk); tx_sof = 0;
    repeat (3) @(negedge clk);
    tx_done = 1; @(negedge clk); tx_done = 0;
  endtask

  task automatic rx_serve(input logic [13:0] len, input bit err, input bit bad, input bit sof,
                          input logic [31:0] s, input logic [31:0] ns);
    if (sof) begin
      @(negedge clk); ts_sec = s; ts_nsec = ns; rx_sof = 1; @(negedge clk); rx_sof = 0;
    end
    rx_cpl_valid = 1; rx_cpl_len = len; rx_cpl_err = err; rx_cpl_ts_bad = bad;
    while (!rx_cpl_ready) @(negedge clk);
    @(negedge clk); rx_cpl_valid = 0; rx_cpl_ts_bad = 0; rx_cpl_err = 0;
  endtask

  function automatic logic [31:0] rxw0(input logic [13:0] len, input bit err);
    return (32'(len) << 16) | (32'(err) << 15) | 32'h100;
  endfunction

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0;
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    mem[0] = OWN | TSE | 32'h123; mem[1] = 32'd100;
    mem[64] = OWN; mem[72] = OWN; mem[88] = OWN;
    mem[86] = 32'hA5A5_0000; mem[87] = 32'hA5A5_0001;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_req_valid, "R1 mem_req_valid", 32'(mem_req_valid), 0);
    chk(!tx_req_valid, "R1 tx_req_valid", 32'(tx_req_valid), 0);
    chk(!rx_cpl_ready, "R1 rx_cpl_ready", 32'(rx_cpl_ready), 0);

    // R4 timestamped transmit, extended format
    expw(6, 32'd11, "R4 tx sec"); expw(7, 32'd2222, "R4 tx nsec");
    expw(0, TSE | 32'h123, "R4 tx ctl");
    pulse_txp();
    tx_serve(14'd100, 32'd11, 32'd2222, "R3 tx len");
    drain();

    // R4 no timestamp when enable bit clear
    mem[8] = OWN | 32'h5; mem[9] = 32'd64;
    expw(8, 32'h5, "R4 tx ctl only");
    pulse_txp();
    tx_serve(14'd64, 32'd1, 32'd2, "R3 tx len2");
    drain();

    // R2 unowned transmit descriptor: one read then silence
    c0 = acc_cnt;
    pulse_txp();
    repeat (30) begin
      @(negedge clk);
      if (tx_req_valid) chk(0, "R2 request on unowned", 1, 0);
    end
    chk(acc_cnt == c0 + 1, "R2 accesses", 32'(acc_cnt - c0), 1);

    // R8 short format at index 2 -> word 8
    cfg_ext_desc = 0;
    mem[8] = OWN | TSE | 32'h7; mem[9] = 32'd48;
    expw(8, TSE | 32'h7, "R8 short ctl");
    pulse_txp();
    tx_serve(14'd48, 32'd3, 32'd4, "R8 tx len");
    drain();
    // R9 index 3 then wrap to 0
    mem[12] = OWN | 32'h9; mem[13] = 32'd20;
    expw(12, 32'h9, "R9 tx slot3");
    pulse_txp();
    tx_serve(14'd20, 32'd5, 32'd6, "R9 tx len3");
    drain();
    mem[0] = OWN | 32'h1; mem[1] = 32'd30;
    expw(0, 32'h1, "R9 tx wrap");
    pulse_txp();
    tx_serve(14'd30, 32'd7, 32'd8, "R9 tx len wrap");
    drain();
    cfg_ext_desc = 1;

    // R5 receive with capture
    rx_run = 1;
    expw(70, 32'd5, "R5 rx sec"); expw(71, 32'd1000, "R5 rx nsec");
    expw(64, rxw0(14'd200, 0), "R5 rx status");
    rx_serve(14'd200, 0, 0, 1, 32'd5, 32'd1000);
    drain();
    // R6 capture lost flag
    expw(78, ONES, "R6 rx bad sec"); expw(79, ONES, "R6 rx bad nsec");
    expw(72, rxw0(14'd300, 1), "R5 rx err status");
    rx_serve(14'd300, 1, 1, 1, 32'd6, 32'd77);
    drain();

    // R10 descriptor 2 not owned: back-pressure
    c0 = acc_cnt;
    rx_cpl_valid = 1; rx_cpl_len = 14'd64;
    repeat (20) @(negedge clk);
    chk(!rx_cpl_ready, "R10 ready on unowned", 32'(rx_cpl_ready), 0);
    chk(acc_cnt == c0, "R10 idle accesses", 32'(acc_cnt - c0), 0);
    rx_cpl_valid = 0;
    // R7 timestamps off
    cfg_ts_en = 0;
    mem[80] = OWN;
    expw(80, rxw0(14'd64, 0), "R7 rx status only");
    @(negedge clk); rx_poll = 1; @(negedge clk); rx_poll = 0;
    rx_serve(14'd64, 0, 0, 1, 32'd9, 32'd9);
    drain();
    chk(mem[86] == 32'hA5A5_0000, "R7 word6 kept", mem[86], 32'hA5A5_0000);
    chk(mem[87] == 32'hA5A5_0001, "R7 word7 kept", mem[87], 32'hA5A5_0001);

    // R6 no capture since last frame, and R11 stop during writeback
    cfg_ts_en = 1;
    expw(94, ONES, "R6 nocap sec"); expw(95, ONES, "R6 nocap nsec");
    expw(88, rxw0(14'd90, 0), "R11 rx status");
    rx_serve(14'd90, 0, 0, 0, 0, 0);
    rx_run = 0;
    drain();
    c0 = acc_cnt;
    repeat (30) @(negedge clk);
    chk(acc_cnt == c0, "R11 stopped accesses", 32'(acc_cnt - c0), 0);
    chk(!rx_cpl_ready, "R11 ready while stopped", 32'(rx_cpl_ready), 0);

    // R9 receive wrap to descriptor 0
    mem[64] = OWN;
    rx_run = 1;
    expw(70, 32'd9, "R9 rx wrap sec"); expw(71, 32'd77, "R9 rx wrap nsec");
    expw(64, rxw0(14'd128, 0), "R9 rx wrap status");
    rx_serve(14'd128, 0, 0, 1, 32'd9, 32'd77);
    drain();
    chk(exp_a.size() == 0, "R12 scoreboard empty", 32'(exp_a.size()), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule